// File: doc/BRIEF.md
# Link Control Register with Cycle Timer

This block holds the 32-bit control word of a serial-bus link layer and the cycle timer it governs. Software never writes the word directly. A write to the set alias (address 0xE0) turns on every bit that carries a 1 in the write data. A write to the clear alias (address 0xE4) turns off every such bit. Bits written as 0 keep their value. Five bits are live:

| Bit | Role |
|-----|------|
| 21 | master enable |
| 20 | timer enable |
| 10 | PHY-packet accept |
| 9 | self-ID accept |
| 6 | tag1 filter lock |

The live bits drive enables towards the receive path. The tag1 lock forces the tag1 synchronisation filter of every isochronous receive context to 1.

The cycle timer has three fields. A 12-bit offset counts ticks of the 24.576 MHz strobe from 0 to 3071. A 13-bit cycle field counts offset wraps from 0 to 7999. A 7-bit seconds field counts cycle wraps and rolls over freely. A three-state machine chooses how the timer behaves:

- **HALT** holds the time.
- **FOLLOW** counts ticks and accepts resynchronising cycle-start values received from the bus.
- **LEAD** counts ticks, ignores received values and requests a cycle-start packet at every offset wrap.

The block has an external cycle-too-long event flag. It clears the master bit and keeps it clear while the flag stays asserted. A synchronous soft reset clears every live bit except the tag1 lock. The asynchronous hard reset clears everything.

Top module: `lnkctl_top`

## Requirements
- R1: A write with address 0xE0 sets each live bit (21, 20, 10, 9, 6) whose write-data bit is 1; other bits are unchanged; the new value is visible on the next cycle.
- R2: A write with address 0xE4 clears each live bit whose write-data bit is 1; other bits are unchanged.
- R3: With the address at 0xE0 or 0xE4, `bus_rdata` shows the register combinationally, with all bits other than 21, 20, 10, 9, 6 reading 0 (bit 22 included); any other address reads 0.
- R4: In any cycle where `cyc_too_long` is high, bit 21 is cleared at the next edge, and a set write of bit 21 in that cycle has no effect; `cyc_master_en` follows bit 21.
- R5: `soft_rst` clears bits 21, 20, 10 and 9 at the next edge, keeps bit 6, and a write in the same cycle is discarded.
- R6: Hard reset (`hrst_n` low) clears all register bits, bit 6 included, and zeroes `cycle_time` and `cycle_start_req`.
- R7: The timer state is registered. Its transitions use the register bits and `is_root` of the previous cycle:
  - any state → HALT when bit 20 is 0;
  - any state → LEAD when bit 20, bit 21 and `is_root` are all 1;
  - any state → FOLLOW when bit 20 is 1 otherwise.
- R8: `cycle_time` is {seconds[31:25], cycle[24:12], offset[11:0]}. In FOLLOW and LEAD each `tick` advances the offset, which wraps after 3071 into a cycle increment; the cycle wraps after 7999 into a seconds increment, and seconds wrap after 127. In HALT the time holds.
- R9: In LEAD, `cycle_start_req` is high for exactly the cycle after an edge whose tick wrapped the offset, and it is never high otherwise.
- R10: In HALT or FOLLOW, `rx_cs_valid` loads `rx_cs_value` into the timer at the next edge, overriding a tick in the same cycle. In LEAD the received value is ignored.
- R11: `phy_pkt_accept` is bit 10 AND `ar_req_ctx_en`; `self_id_accept` is bit 9.
- R12: `tag1_eff[i]` is 1 for every context while bit 6 is set, otherwise it equals `tag1_sw[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address (0xE0 set, 0xE4 clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tick | input | 1 | 24.576 MHz tick enable |
| is_root | input | 1 | Node is bus root |
| cyc_too_long | input | 1 | Cycle-too-long event flag |
| ar_req_ctx_en | input | 1 | Asynchronous receive request context enabled |
| rx_cs_valid | input | 1 | Received cycle-start value is valid |
| rx_cs_value | input | 32 | Received cycle timer value |
| tag1_sw | input | N_IR | Software tag1 filter bits per isochronous context |
| tag1_eff | output | N_IR | Effective tag1 filter bits |
| cyc_master_en | output | 1 | Master bit (21) |
| timer_en | output | 1 | Timer enable bit (20) |
| phy_pkt_accept | output | 1 | Accept PHY packets |
| self_id_accept | output | 1 | Accept self-ID packets |
| cycle_time | output | 32 | Current cycle timer |
| cycle_start_req | output | 1 | Cycle-start request pulse |

## Verification
Two pairs of functions can land in the same cycle:

- **Cycle-too-long event and a set write of the master bit.** The bench raises the event in the same cycle as the write and holds it for a second write. The master bit must read back 0 both times, and it must be settable again once the flag drops.
- **Timer load and tick.** A received cycle-start value arrives together with a tick. In FOLLOW the loaded value must appear unchanged. In LEAD the timer must advance as if nothing had been received.

A behavioural reference model is compared with the outputs every cycle. Random traffic makes these collisions, soft-reset-versus-write clashes and wraps of the offset and cycle fields occur repeatedly.

// File: rtl/lnkctl_pkg.sv
`timescale 1ns/1ps
package lnkctl_pkg;
    localparam int CTL_W       = 32;
    localparam int BIT_MASTER  = 21;
    localparam int BIT_TMR_EN  = 20;
    localparam int BIT_PHY_ACC = 10;
    localparam int BIT_SID_ACC = 9;
    localparam int BIT_T1_LOCK = 6;

    localparam logic [CTL_W-1:0] LIVE_MASK =
        (32'd1 << BIT_MASTER) | (32'd1 << BIT_TMR_EN) |
        (32'd1 << BIT_PHY_ACC) | (32'd1 << BIT_SID_ACC) |
        (32'd1 << BIT_T1_LOCK);
    localparam logic [CTL_W-1:0] SOFT_KEEP = 32'd1 << BIT_T1_LOCK;

    localparam int SEC_W = 7;
    localparam int CYC_W = 13;
    localparam int OFS_W = 12;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CYC_W-1:0] cyc;
        logic [OFS_W-1:0] ofs;
    } ctime_t;

    typedef enum logic [1:0] {
        TM_HALT   = 2'd0,
        TM_FOLLOW = 2'd1,
        TM_LEAD   = 2'd2
    } tmode_e;
endpackage

// File: rtl/lnkctl_regfile.sv
`timescale 1ns/1ps
module lnkctl_regfile
    import lnkctl_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SET_ADDR = 8'hE0,
    parameter logic [ADDR_W-1:0] CLR_ADDR = 8'hE4
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTL_W-1:0]  bus_wdata,
    input  logic              cyc_too_long,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [CTL_W-1:0]  bus_rdata
);
    logic             set_hit, clr_hit;
    logic [CTL_W-1:0] wmask;
    logic [CTL_W-1:0] ctl_d;

    assign set_hit = bus_wr && (bus_addr == SET_ADDR);
    assign clr_hit = bus_wr && (bus_addr == CLR_ADDR);
    assign wmask   = bus_wdata & LIVE_MASK;

    always_comb begin
        ctl_d = ctl_q;
        if (soft_rst) begin
            ctl_d = ctl_q & SOFT_KEEP;
        end else begin
            if (set_hit) ctl_d = ctl_d | wmask;
            if (clr_hit) ctl_d = ctl_d & ~wmask;
        end
        if (cyc_too_long) ctl_d[BIT_MASTER] = 1'b0;
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) ctl_q <= '0;
        else         ctl_q <= ctl_d & LIVE_MASK;
    end

    assign bus_rdata = (bus_addr == SET_ADDR || bus_addr == CLR_ADDR) ? ctl_q : '0;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!hrst_n)
        (set_hit && !clr_hit && !soft_rst && !cyc_too_long) |=>
        ((ctl_q & $past(wmask)) == $past(wmask))) else $error("set alias"); // R1
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!hrst_n)
        (clr_hit && !soft_rst) |=> ((ctl_q & $past(wmask)) == '0)) else $error("clear alias"); // R2
    AST_MASTER_GATED: assert property (@(posedge clk) disable iff (!hrst_n)
        cyc_too_long |=> !ctl_q[BIT_MASTER]) else $error("master gate"); // R4
    AST_SOFT_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!hrst_n)
        soft_rst |=> (ctl_q == ($past(ctl_q) & SOFT_KEEP))) else $error("soft reset"); // R5
endmodule

// File: rtl/lnkctl_cycle_timer.sv
`timescale 1ns/1ps
module lnkctl_cycle_timer
    import lnkctl_pkg::*;
#(
    parameter int OFS_LIMIT = 3072,
    parameter int CYC_LIMIT = 8000
) (
    input  logic   clk,
    input  logic   hrst_n,
    input  logic   ctl_en,
    input  logic   ctl_master,
    input  logic   is_root,
    input  logic   tick,
    input  logic   rx_cs_valid,
    input  ctime_t rx_cs_value,
    output ctime_t t_q,
    output logic   start_q,
    output tmode_e mode_q
);
    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(OFS_LIMIT - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_LIMIT - 1);

    tmode_e mode_d;
    ctime_t t_d, t_adv;
    logic   start_d, ofs_last, cyc_last, lead_ok;

    assign lead_ok = ctl_master && is_root;

    // state transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            TM_HALT:   if (ctl_en) mode_d = lead_ok ? TM_LEAD : TM_FOLLOW;
            TM_FOLLOW: if (!ctl_en) mode_d = TM_HALT;
                       else if (lead_ok) mode_d = TM_LEAD;
            TM_LEAD:   if (!ctl_en) mode_d = TM_HALT;
                       else if (!lead_ok) mode_d = TM_FOLLOW;
            default:   mode_d = TM_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) mode_q <= TM_HALT;
        else         mode_q <= mode_d;
    end

    // advance arithmetic
    assign ofs_last = (t_q.ofs == OFS_LAST);
    assign cyc_last = (t_q.cyc == CYC_LAST);

    always_comb begin
        t_adv     = t_q;
        t_adv.ofs = ofs_last ? '0 : t_q.ofs + 1'b1;
        if (ofs_last) begin
            t_adv.cyc = cyc_last ? '0 : t_q.cyc + 1'b1;
            if (cyc_last) t_adv.sec = t_q.sec + 1'b1;
        end
    end

    // per-state outputs
    always_comb begin
        t_d     = t_q;
        start_d = 1'b0;
        unique case (mode_q)
            TM_HALT:   if (rx_cs_valid) t_d = rx_cs_value;
            TM_FOLLOW: if (rx_cs_valid) t_d = rx_cs_value;
                       else if (tick)   t_d = t_adv;
            TM_LEAD:   if (tick) begin
                           t_d     = t_adv;
                           start_d = ofs_last;
                       end
            default:   t_d = t_q;
        endcase
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            t_q     <= '0;
            start_q <= 1'b0;
        end else begin
            t_q     <= t_d;
            start_q <= start_d;
        end
    end

    AST_ENTER_LEAD: assert property (@(posedge clk) disable iff (!hrst_n)
        (ctl_en && ctl_master && is_root) |=> (mode_q == TM_LEAD)) else $error("lead entry"); // R7
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!hrst_n)
        (mode_q == TM_HALT && !rx_cs_valid) |=> $stable(t_q)) else $error("halt hold"); // R8
    AST_OFS_WRAP: assert property (@(posedge clk) disable iff (!hrst_n)
        (tick && ofs_last && (mode_q == TM_LEAD || (mode_q == TM_FOLLOW && !rx_cs_valid)))
        |=> (t_q.ofs == '0)) else $error("offset wrap"); // R8
    AST_START_ONLY_LEAD: assert property (@(posedge clk) disable iff (!hrst_n)
        start_q |-> ($past(mode_q) == TM_LEAD)) else $error("start pulse"); // R9
    AST_LEAD_IGNORES_RX: assert property (@(posedge clk) disable iff (!hrst_n)
        (mode_q == TM_LEAD && !tick) |=> $stable(t_q)) else $error("lead rx"); // R10
endmodule

// File: rtl/lnkctl_top.sv
`timescale 1ns/1ps
module lnkctl_top
    import lnkctl_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 8'hE0,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'hE4,
    parameter int                N_IR      = 4,
    parameter int                OFS_LIMIT = 3072,
    parameter int                CYC_LIMIT = 8000
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              soft_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick,
    input  logic              is_root,
    input  logic              cyc_too_long,
    input  logic              ar_req_ctx_en,
    input  logic              rx_cs_valid,
    input  logic [31:0]       rx_cs_value,
    input  logic [N_IR-1:0]   tag1_sw,
    output logic [N_IR-1:0]   tag1_eff,
    output logic              cyc_master_en,
    output logic              timer_en,
    output logic              phy_pkt_accept,
    output logic              self_id_accept,
    output logic [31:0]       cycle_time,
    output logic              cycle_start_req
);
    logic [CTL_W-1:0] ctl;
    ctime_t           t_now;
    tmode_e           mode;

    lnkctl_regfile #(.ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_regs (
        .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cyc_too_long(cyc_too_long),
        .ctl_q(ctl), .bus_rdata(bus_rdata)
    );

    lnkctl_cycle_timer #(.OFS_LIMIT(OFS_LIMIT), .CYC_LIMIT(CYC_LIMIT)) u_timer (
        .clk(clk), .hrst_n(hrst_n), .ctl_en(ctl[BIT_TMR_EN]),
        .ctl_master(ctl[BIT_MASTER]), .is_root(is_root), .tick(tick),
        .rx_cs_valid(rx_cs_valid), .rx_cs_value(ctime_t'(rx_cs_value)),
        .t_q(t_now), .start_q(cycle_start_req), .mode_q(mode)
    );

    assign cycle_time     = t_now;
    assign cyc_master_en  = ctl[BIT_MASTER];
    assign timer_en       = ctl[BIT_TMR_EN];
    assign phy_pkt_accept = ctl[BIT_PHY_ACC] & ar_req_ctx_en;
    assign self_id_accept = ctl[BIT_SID_ACC];

    for (genvar gi = 0; gi < N_IR; gi++) begin : g_tag1
        assign tag1_eff[gi] = ctl[BIT_T1_LOCK] | tag1_sw[gi];
    end

    AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!hrst_n)
        (mode == TM_HALT) |=> !cycle_start_req) else $error("halt start"); // R9
endmodule

// File: tb/lnkctl_top_tb_top.sv
`timescale 1ns/1ps
module lnkctl_top_tb_top;
    localparam logic [7:0] A_SET = 8'hE0;
    localparam logic [7:0] A_CLR = 8'hE4;

    logic        clk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        soft_rst = 0, bus_wr = 0, tick = 0, is_root = 0;
    logic        cyc_too_long = 0, ar_req_ctx_en = 0, rx_cs_valid = 0;
    logic [7:0]  bus_addr = A_SET;
    logic [31:0] bus_wdata = 0, rx_cs_value = 0;
    logic [3:0]  tag1_sw = 0;
    logic [31:0] bus_rdata, cycle_time;
    logic [3:0]  tag1_eff;
    logic        cyc_master_en, timer_en, phy_pkt_accept, self_id_accept, cycle_start_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lnkctl_top dut_i (
        .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .is_root(is_root), .cyc_too_long(cyc_too_long),
        .ar_req_ctx_en(ar_req_ctx_en), .rx_cs_valid(rx_cs_valid),
        .rx_cs_value(rx_cs_value), .tag1_sw(tag1_sw), .tag1_eff(tag1_eff),
        .cyc_master_en(cyc_master_en), .timer_en(timer_en),
        .phy_pkt_accept(phy_pkt_accept), .self_id_accept(self_id_accept),
        .cycle_time(cycle_time), .cycle_start_req(cycle_start_req)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int unsigned m_ctl;   // live bits only
    int          m_mode;  // 0 halt, 1 follow, 2 lead
    int          m_ofs, m_cyc, m_sec;
    bit          m_start;
    localparam int unsigned LIVE = 32'h0030_0640;

    always @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            m_ctl = 0; m_mode = 0; m_ofs = 0; m_cyc = 0; m_sec = 0; m_start = 0;
        end else begin
            m_start = 0;
            if (m_mode != 2 && rx_cs_valid) begin
                m_sec = rx_cs_value[31:25]; m_cyc = rx_cs_value[24:12]; m_ofs = rx_cs_value[11:0];
            end else if (m_mode != 0 && tick) begin
                m_ofs++;
                if (m_ofs == 3072) begin
                    m_ofs = 0; m_cyc++;
                    if (m_mode == 2) m_start = 1;
                    if (m_cyc == 8000) begin
                        m_cyc = 0; m_sec = (m_sec + 1) % 128;
                    end
                end
            end
            if (!m_ctl[20]) m_mode = 0;
            else if (m_ctl[21] && is_root) m_mode = 2;
            else m_mode = 1;
            if (soft_rst) m_ctl = m_ctl & 32'h40;
            else begin
                if (bus_wr && bus_addr == A_SET) m_ctl = m_ctl | (bus_wdata & LIVE);
                if (bus_wr && bus_addr == A_CLR) m_ctl = m_ctl & ~(bus_wdata & LIVE);
            end
            if (cyc_too_long) m_ctl[21] = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk("R3 read", bus_rdata, (bus_addr == A_SET || bus_addr == A_CLR) ? m_ctl : 0);
            chk("R8 time", cycle_time, {m_sec[6:0], m_cyc[12:0], m_ofs[11:0]});
            chk("R9 start", {31'd0, cycle_start_req}, {31'd0, m_start});
            chk("R4 master", {31'd0, cyc_master_en}, {31'd0, m_ctl[21]});
            chk("R7 enable", {31'd0, timer_en}, {31'd0, m_ctl[20]});
            chk("R11 phy", {31'd0, phy_pkt_accept}, {31'd0, m_ctl[10] & ar_req_ctx_en});
            chk("R11 selfid", {31'd0, self_id_accept}, {31'd0, m_ctl[9]});
            chk("R12 tag1", {28'd0, tag1_eff}, {28'd0, m_ctl[6] ? 4'hF : tag1_sw});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_wr = 0; soft_rst = 0; rx_cs_valid = 0;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_addr = A_SET;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        hrst_n = 1;
        step();
        @(negedge clk);
        chk("R6 reset read", bus_rdata, 32'h0);
        chk("R6 reset time", cycle_time, 32'h0);
        step();

        wr(A_SET, 32'hFFFF_FFFF);
        @(negedge clk); chk("R1 set all", bus_rdata, 32'h0030_0640);
        bus_addr = 8'h10; #1; chk("R3 other addr", bus_rdata, 32'h0);
        bus_addr = A_CLR; #1; chk("R3 clear alias read", bus_rdata, 32'h0030_0640);
        step();

        wr(A_CLR, 32'h0020_0400);
        @(negedge clk); chk("R2 clear", bus_rdata, 32'h0010_0240);
        step();

        cyc_too_long = 1;
        wr(A_SET, 32'h0020_0000);
        wr(A_SET, 32'h0020_0000);
        @(negedge clk); chk("R4 blocked", bus_rdata, 32'h0010_0240);
        step();
        cyc_too_long = 0;
        wr(A_SET, 32'h0020_0400);
        @(negedge clk); chk("R4 released", bus_rdata, 32'h0030_0640);
        chk("R11 ctx off", {31'd0, phy_pkt_accept}, 32'd0);
        step();
        ar_req_ctx_en = 1; tag1_sw = 4'b0101;
        @(negedge clk);
        chk("R11 ctx on", {31'd0, phy_pkt_accept}, 32'd1);
        chk("R12 forced", {28'd0, tag1_eff}, 32'hF);
        step();

        soft_rst = 1; bus_wr = 1; bus_addr = A_SET; bus_wdata = 32'hFFFF_FFFF;
        step();
        @(negedge clk); chk("R5 soft reset", bus_rdata, 32'h0000_0040);
        chk("R12 lock kept", {28'd0, tag1_eff}, 32'hF);
        step();
        wr(A_CLR, 32'h0000_0040);
        @(negedge clk); chk("R12 released", {28'd0, tag1_eff}, 32'h5);
        step();

        // timer: follow, load, then lead and wrap
        wr(A_SET, 32'h0010_0000);
        step();
        rx_cs_value = {7'd127, 13'd7999, 12'd3070}; rx_cs_valid = 1; tick = 1;
        step(); tick = 0;
        @(negedge clk); chk("R10 load", cycle_time, {7'd127, 13'd7999, 12'd3070});
        step();
        is_root = 1;
        wr(A_SET, 32'h0020_0000);
        step();
        rx_cs_value = 32'h0; rx_cs_valid = 1;
        step();
        @(negedge clk); chk("R10 lead ignores", cycle_time, {7'd127, 13'd7999, 12'd3070});
        step();
        tick = 1; rx_cs_valid = 1; rx_cs_value = 32'h0000_0123;
        step();
        step();
        tick = 0;
        @(negedge clk);
        chk("R8 full wrap", cycle_time, 32'h0);
        chk("R9 pulse", {31'd0, cycle_start_req}, 32'd1);
        step();
        @(negedge clk); chk("R9 one cycle", {31'd0, cycle_start_req}, 32'd0);
        wr(A_CLR, 32'h0010_0000);
        step();
        tick = 1; step(4); tick = 0;
        @(negedge clk); chk("R8 halt hold", cycle_time, 32'h0);

        wr(A_SET, 32'h0000_0040);
        hrst_n = 0; step(); hrst_n = 1;
        @(negedge clk); chk("R6 hard reset", bus_rdata, 32'h0);

        // random traffic
        for (int k = 0; k < 8000; k++) begin
            @(posedge clk); #1;
            bus_wr = ($urandom_range(3) == 0);
            case ($urandom_range(3))
                0, 1: bus_addr = A_SET;
                2: bus_addr = A_CLR;
                default: bus_addr = 8'($urandom);
            endcase
            bus_wdata = ($urandom_range(2) == 0) ? $urandom : 32'h0030_0200;
            soft_rst = ($urandom_range(199) == 0);
            cyc_too_long = ($urandom_range(49) == 0);
            is_root = ($urandom_range(9) != 0);
            tick = ($urandom_range(7) != 0);
            ar_req_ctx_en = $urandom_range(1);
            tag1_sw = 4'($urandom);
            rx_cs_valid = ($urandom_range(99) == 0);
            rx_cs_value = {7'($urandom), 13'($urandom_range(7999)),
                           12'(($urandom_range(1) == 0) ? $urandom_range(3071) : 3060 + $urandom_range(11))};
        end
        step(2);
        finish_run();
    end
endmodule